// File: doc/BRIEF.md
# Mode-Switched Dual 8-Bit GPIO Port

This block holds two 8-bit general-purpose I/O ports: a data register and a direction register for each, all behind a small register bus. The 16 pins are ordered with the first port on pin bits 15..8 and the second port on pin bits 7..0.

A 2-bit operating-mode input decides who owns the pins:
- In single-chip mode the registers drive the pins, and each direction bit gates that pin's output enable.
- In expanded mode the pins carry a 16-bit external address.
- In emulation mode the pins carry that address during the first half of a bus cycle and a 16-bit visibility word during the second half.
- In either alternate mode, pin bit 0 may instead carry an upper-data-strobe level.

In emulation mode, data-register reads come from an external-bus read input. Data-register writes are copied to the external bus as a one-cycle strobe. Pin inputs are resynchronised through two flops before any read path sees them.

Top module: `gpio_pair_port`

## Requirements
- R1: After reset all four registers read 0x00, `ext_wr_stb` is 0, and in single-chip mode `pin_oe` is 0x0000.
- R2: A bus write (`bus_sel`=1, `bus_wr`=1) updates the register at `bus_addr` at the next clock edge, in any mode. The offsets are: 0 = first-port data, 1 = second-port data, 2 = first-port direction, 3 = second-port direction. Direction registers always read back their own contents.
- R3: Outside emulation mode, a read of offset 0 or 1 returns, per bit, the data-register bit where the direction bit is 1 and the synchronised pin input where it is 0.
- R4: A change on `pin_in` reaches the read path after two rising clock edges, not after one.
- R5: In single-chip mode (`mode`=00) and in the unused code `mode`=11: `pin_out` = {first data, second data} and `pin_oe` = {first direction, second direction}.
- R6: In expanded mode (`mode`=01), `pin_out` = `ext_addr`, with the first port carrying bits 15..8. `pin_oe` is 0xFFFF whatever the direction registers hold.
- R7: In emulation mode (`mode`=10), `pin_out` = `ext_addr` when `mux_phase`=0 and `ivd_data` when `mux_phase`=1. `pin_oe` is 0xFFFF.
- R8: In expanded or emulation mode with `uds_en`=1, `pin_out[0]` = `uds_n`. All other pins are unaffected.
- R9: In emulation mode, a read of offset 0 or 1 returns `ext_rdata`.
- R10: A write to offset 0 or 1 in emulation mode updates the register, and in the next cycle raises `ext_wr_stb` for exactly one cycle, with `ext_wr_addr` and `ext_wr_data` equal to the written offset and data. No other write raises the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| mode | input | 2 | 00 single-chip, 01 expanded, 10 emulation, 11 treated as single-chip |
| bus_sel | input | 1 | Register access valid |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| ext_rdata | input | 8 | External-bus read data used in emulation mode |
| ext_addr | input | 16 | External address for the alternate pin function |
| ivd_data | input | 16 | Visibility data for the second half of the cycle |
| mux_phase | input | 1 | 0 = address half, 1 = visibility half |
| uds_en | input | 1 | Pin bit 0 carries the upper data strobe |
| uds_n | input | 1 | Upper-data-strobe level |
| pin_in | input | 16 | Pad inputs |
| pin_out | output | 16 | Pad output values |
| pin_oe | output | 16 | Pad output enables |
| ext_wr_stb | output | 1 | Mirrored write strobe |
| ext_wr_addr | output | 2 | Mirrored write offset |
| ext_wr_data | output | 8 | Mirrored write data |

## Verification
A data-register write in emulation mode lands in the same cycle as the mode-dependent pin multiplex. The register update and the bus mirror occur together, while the pins still show address or visibility data.

The bench provokes this with random writes under random mode, phase and strobe settings. It then judges three things together:
- the strobe fields in the following cycle;
- the pins, which must not reflect the new register value in alternate modes;
- a later readback of that register in a non-emulation mode.

// File: rtl/gpio_pair_pkg.sv
package gpio_pair_pkg;
  typedef enum logic [1:0] {
    MODE_SINGLE   = 2'b00,
    MODE_EXPANDED = 2'b01,
    MODE_EMULATE  = 2'b10,
    MODE_RSVD     = 2'b11
  } op_mode_e;

  localparam int unsigned NUM_PORTS = 2;
  localparam int unsigned NUM_REGS  = 2 * NUM_PORTS;
  localparam int unsigned OFF_W     = $clog2(NUM_REGS);

  function automatic logic mode_is_alt(input logic [1:0] m);
    return (m == MODE_EXPANDED) || (m == MODE_EMULATE);
  endfunction
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg1_q, stg2_q;
  logic [W-1:0] stg1_nxt, stg2_nxt;

  always_comb begin
    stg1_nxt = d;
    stg2_nxt = stg1_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg1_q <= '0;
      stg2_q <= '0;
    end else begin
      stg1_q <= stg1_nxt;
      stg2_q <= stg2_nxt;
    end
  end

  assign q = stg2_q;
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs #(
  parameter int PORT_W = 8,
  parameter int NREG   = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NREG-1:0]              wr_en,
  input  logic [PORT_W-1:0]            wdata,
  output logic [NREG-1:0][PORT_W-1:0]  q
);
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic [PORT_W-1:0] r_q, r_nxt;

    always_comb begin
      r_nxt = wr_en[g] ? wdata : r_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        r_q <= '0;
      else if (wr_en[g]) r_q <= r_nxt;
    end

    assign q[g] = r_q;

    assert_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en[g] |=> (q[g] == $past(wdata)));
    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en[g] |=> $stable(q[g]));
  end
endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux
  import gpio_pair_pkg::*;
#(
  parameter int PIN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode,
  input  logic             mux_phase,
  input  logic [PIN_W-1:0] ext_addr,
  input  logic [PIN_W-1:0] ivd_data,
  input  logic             uds_en,
  input  logic             uds_n,
  input  logic [PIN_W-1:0] gpio_out,
  input  logic [PIN_W-1:0] gpio_oe,
  output logic [PIN_W-1:0] pin_out,
  output logic [PIN_W-1:0] pin_oe
);
  logic             alt;
  logic [PIN_W-1:0] alt_val;

  always_comb begin
    alt     = mode_is_alt(mode);
    alt_val = ((mode == MODE_EMULATE) && mux_phase) ? ivd_data : ext_addr;
    if (uds_en) alt_val[0] = uds_n;
    pin_out = alt ? alt_val : gpio_out;
    pin_oe  = alt ? '1 : gpio_oe;
  end

  assert_alt_oe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == MODE_EXPANDED) || (mode == MODE_EMULATE)) |-> (&pin_oe));
  assert_gpio_own_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == MODE_SINGLE) || (mode == MODE_RSVD)) |-> (pin_oe == gpio_oe));
endmodule

// File: rtl/gpio_pair_port.sv
module gpio_pair_port
  import gpio_pair_pkg::*;
#(
  parameter  int PORT_W = 8,
  localparam int PIN_W  = NUM_PORTS * PORT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [OFF_W-1:0]  bus_addr,
  input  logic [PORT_W-1:0] bus_wdata,
  output logic [PORT_W-1:0] bus_rdata,
  input  logic [PORT_W-1:0] ext_rdata,
  input  logic [PIN_W-1:0]  ext_addr,
  input  logic [PIN_W-1:0]  ivd_data,
  input  logic              mux_phase,
  input  logic              uds_en,
  input  logic              uds_n,
  input  logic [PIN_W-1:0]  pin_in,
  output logic [PIN_W-1:0]  pin_out,
  output logic [PIN_W-1:0]  pin_oe,
  output logic              ext_wr_stb,
  output logic [OFF_W-1:0]  ext_wr_addr,
  output logic [PORT_W-1:0] ext_wr_data
);
  logic [NUM_REGS-1:0][PORT_W-1:0] reg_q;
  logic [NUM_REGS-1:0]             wr_en;
  logic [PIN_W-1:0]                pin_sync;
  logic [PIN_W-1:0]                gpio_out, gpio_oe;
  logic [NUM_PORTS-1:0][PORT_W-1:0] mix_rd;

  logic              is_emu, data_wr, mirror_go;
  logic              stb_q, stb_nxt;
  logic [OFF_W-1:0]  waddr_q, waddr_nxt;
  logic [PORT_W-1:0] wdat_q, wdat_nxt;

  assign is_emu = (mode == MODE_EMULATE);

  always_comb begin
    for (int i = 0; i < NUM_REGS; i++)
      wr_en[i] = bus_sel && bus_wr && (bus_addr == OFF_W'(i));
  end

  gpio_in_sync #(.W(PIN_W)) i_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pin_sync)
  );

  gpio_port_regs #(.PORT_W(PORT_W), .NREG(NUM_REGS)) i_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wdata(bus_wdata), .q(reg_q)
  );

  // Port p owns pin slice [PIN_W-1-p*PORT_W -: PORT_W]; data at offset p, direction at p+NUM_PORTS.
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    localparam int HI = PIN_W - 1 - p * PORT_W;
    assign gpio_out[HI -: PORT_W] = reg_q[p];
    assign gpio_oe [HI -: PORT_W] = reg_q[p + NUM_PORTS];
    assign mix_rd[p] = (reg_q[p + NUM_PORTS] & reg_q[p]) |
                       (~reg_q[p + NUM_PORTS] & pin_sync[HI -: PORT_W]);
  end

  always_comb begin
    if (int'(bus_addr) >= NUM_PORTS) bus_rdata = reg_q[bus_addr];
    else if (is_emu)                 bus_rdata = ext_rdata;
    else                             bus_rdata = mix_rd[bus_addr[0]];
  end

  gpio_pin_mux #(.PIN_W(PIN_W)) i_mux (
    .clk(clk), .rst_n(rst_n), .mode(mode), .mux_phase(mux_phase),
    .ext_addr(ext_addr), .ivd_data(ivd_data), .uds_en(uds_en), .uds_n(uds_n),
    .gpio_out(gpio_out), .gpio_oe(gpio_oe), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  // Emulation write mirror
  always_comb begin
    data_wr   = bus_sel && bus_wr && (int'(bus_addr) < NUM_PORTS);
    mirror_go = data_wr && is_emu;
    stb_nxt   = mirror_go;
    waddr_nxt = bus_addr;
    wdat_nxt  = bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stb_q <= 1'b0;
    else        stb_q <= stb_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      waddr_q <= '0;
      wdat_q  <= '0;
    end else if (mirror_go) begin
      waddr_q <= waddr_nxt;
      wdat_q  <= wdat_nxt;
    end
  end

  assign ext_wr_stb  = stb_q;
  assign ext_wr_addr = waddr_q;
  assign ext_wr_data = wdat_q;

  assert_stb_src_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ext_wr_stb |-> $past(bus_sel && bus_wr && (mode == MODE_EMULATE) && (int'(bus_addr) < NUM_PORTS)));
  assert_stb_data_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ext_wr_stb |-> (ext_wr_data == $past(bus_wdata)) && (ext_wr_addr == $past(bus_addr)));
  assert_emu_rd_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (is_emu && (int'(bus_addr) < NUM_PORTS)) |-> (bus_rdata == ext_rdata));
endmodule

// File: tb/test_gpio_pair_port.sv
`timescale 1ns/1ps
module test_gpio_pair_port;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  mode;
  logic        bus_sel, bus_wr;
  logic [1:0]  bus_addr;
  logic [7:0]  bus_wdata, bus_rdata, ext_rdata;
  logic [15:0] ext_addr, ivd_data, pin_in, pin_out, pin_oe;
  logic        mux_phase, uds_en, uds_n;
  logic        ext_wr_stb;
  logic [1:0]  ext_wr_addr;
  logic [7:0]  ext_wr_data;

  int nchk = 0;
  int nfail = 0;
  logic [7:0] m_reg [4];

  always #4 clk = ~clk;

  gpio_pair_port i_gpio_pair_port (
    .clk(clk), .rst_n(rst_n), .mode(mode), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ext_rdata(ext_rdata), .ext_addr(ext_addr), .ivd_data(ivd_data),
    .mux_phase(mux_phase), .uds_en(uds_en), .uds_n(uds_n), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .ext_wr_stb(ext_wr_stb),
    .ext_wr_addr(ext_wr_addr), .ext_wr_data(ext_wr_data)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic is_alt(input logic [1:0] m);
    return (m == 2'b01) || (m == 2'b10);
  endfunction

  function automatic logic [15:0] f_out(input logic [1:0] m);
    logic [15:0] r;
    if (is_alt(m)) begin
      r = (m == 2'b10 && mux_phase) ? ivd_data : ext_addr;
      if (uds_en) r[0] = uds_n;
    end else r = {m_reg[0], m_reg[1]};
    return r;
  endfunction

  function automatic logic [15:0] f_oe(input logic [1:0] m);
    return is_alt(m) ? 16'hFFFF : {m_reg[2], m_reg[3]};
  endfunction

  function automatic logic [7:0] f_rd(input logic [1:0] m, input logic [1:0] a, input logic [15:0] pins);
    logic [7:0] pv;
    if (a >= 2) return m_reg[a];
    if (m == 2'b10) return ext_rdata;
    pv = (a == 0) ? pins[15:8] : pins[7:0];
    return (m_reg[a+2] & m_reg[a]) | (~m_reg[a+2] & pv);
  endfunction

  task automatic do_write(input logic [1:0] a, input logic [7:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
    m_reg[a] = d;
    #1;
  endtask

  task automatic check_pins(input string tag);
    chk(pin_out, f_out(mode), {tag, " pin_out"});
    chk(pin_oe, f_oe(mode), {tag, " pin_oe"});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired actual=%0d expected=done", nchk);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    logic [31:0] seed;
    seed = 32'd1234;
    void'($urandom(seed));
    for (int i = 0; i < 4; i++) m_reg[i] = 8'h00;
    rst_n = 1'b0; mode = 2'b00; bus_sel = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
    ext_rdata = 0; ext_addr = 0; ivd_data = 0; mux_phase = 0; uds_en = 0; uds_n = 0;
    pin_in = 16'h0000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;

    // R1: reset state
    for (int a = 0; a < 4; a++) begin
      bus_addr = 2'(a); bus_sel = 1'b1; #1;
      chk(bus_rdata, 8'h00, "R1 reset read");
    end
    bus_sel = 1'b0;
    chk(pin_oe, 16'h0000, "R1 reset pin_oe");
    chk(ext_wr_stb, 1'b0, "R1 reset strobe");

    // R4: two-edge synchroniser
    pin_in = 16'hA5A5;
    repeat (3) @(negedge clk);
    pin_in = 16'h5A5A; bus_addr = 2'd0; bus_sel = 1'b1;
    @(negedge clk); #1;
    chk(bus_rdata, 8'hA5, "R4 one edge old value");
    @(negedge clk); #1;
    chk(bus_rdata, 8'h5A, "R4 two edges new value");
    bus_sel = 1'b0;

    // R2/R3/R5: directed mixed direction read, single mode
    do_write(2'd0, 8'hF0);
    do_write(2'd2, 8'h3C);
    bus_sel = 1'b1; bus_addr = 2'd0; #1;
    chk(bus_rdata, f_rd(2'b00, 2'd0, pin_in), "R3 mixed read");
    bus_addr = 2'd2; #1;
    chk(bus_rdata, 8'h3C, "R2 direction readback");
    bus_sel = 1'b0;
    check_pins("R5 single");

    // R10: back-to-back emulation writes, then a non-data write
    mode = 2'b10;
    do_write(2'd1, 8'h81);
    chk({ext_wr_stb, ext_wr_addr, ext_wr_data}, {1'b1, 2'd1, 8'h81}, "R10 strobe first");
    do_write(2'd3, 8'h7E);
    chk(ext_wr_stb, 1'b0, "R10 no strobe for direction write");
    @(negedge clk); #1;
    chk(ext_wr_stb, 1'b0, "R10 strobe single cycle");

    // Random mix
    for (int it = 0; it < 400; it++) begin
      logic [1:0] op_addr;
      logic [7:0] op_data;
      logic       is_wr;
      @(negedge clk);
      mode      = 2'($urandom_range(0, 3));
      mux_phase = 1'($urandom);
      uds_en    = 1'($urandom);
      uds_n     = 1'($urandom);
      ext_addr  = 16'($urandom);
      ivd_data  = 16'($urandom);
      ext_rdata = 8'($urandom);
      pin_in    = 16'($urandom);
      op_addr   = 2'($urandom);
      op_data   = 8'($urandom);
      is_wr     = 1'($urandom);
      @(negedge clk); @(negedge clk); #1;
      case (mode)
        2'b01:   check_pins("R6 expanded");
        2'b10:   check_pins(mux_phase ? "R7 emu visibility" : "R7 emu address");
        default: check_pins("R5 single");
      endcase
      if (is_alt(mode) && uds_en) chk(pin_out[0], uds_n, "R8 strobe pin");
      if (is_wr) begin
        logic exp_stb;
        exp_stb = (mode == 2'b10) && (op_addr < 2);
        do_write(op_addr, op_data);
        chk(ext_wr_stb, exp_stb, "R10 mirror strobe");
        if (exp_stb) chk({ext_wr_addr, ext_wr_data}, {op_addr, op_data}, "R10 mirror fields");
        check_pins("R2 pins after write");
        bus_sel = 1'b1; bus_addr = op_addr; #1;
        if (op_addr >= 2) chk(bus_rdata, op_data, "R2 write readback");
        else chk(bus_rdata, f_rd(mode, op_addr, pin_in), "R2 data write readback");
        bus_sel = 1'b0;
        @(negedge clk); #1;
        chk(ext_wr_stb, 1'b0, "R10 strobe drop");
      end else begin
        bus_sel = 1'b1; bus_addr = op_addr; #1;
        chk(bus_rdata, f_rd(mode, op_addr, pin_in),
            (mode == 2'b10 && op_addr < 2) ? "R9 emu read" : "R3 read");
        bus_sel = 1'b0;
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule